// File: doc/BRIEF.md
# Power-Managed Machine-Cycle Rate Generator

This block produces the single-cycle machine-cycle enable that paces a processor core. It counts ticks of a chosen oscillator source and pulses once for every 4, 64 or 1024 ticks. The divide-by-4 rate is the normal full-speed setting. The two slower rates save power. Software picks the rate through a two-bit divide field and picks the tick source separately: either every crystal clock, or a ring-oscillator tick enable. Both are modelled as clock enables on the crystal clock, so no clock is muxed.

An optional hardware switchback puts the block back at full speed by itself. This happens when an enabled external interrupt request is present, or when any serial-port transmit or receive activity flag is set. The forced setting becomes the stored divide field, so software reads it back. It remains until software writes the field again. A software write that asks for a slow rate is dropped while a switchback condition is present. A new rate is applied only at a machine-cycle boundary, so a machine cycle is never cut short.

Top module: `pm_cycle_rate`

## Requirements
- R1: A synchronous active-high reset sets the divide field to 2'b01 (divide by 4), selects the crystal source (`src_ring_q` = 0) and drives `mc_en` low.
- R2: With the divide field at 2'b01, `mc_en` pulses every 4 ticks. A write of 2'b00 is stored as 2'b01 and gives the same rate.
- R3: With the divide field at 2'b10, `mc_en` pulses every 64 ticks.
- R4: With the divide field at 2'b11, `mc_en` pulses every 1024 ticks.
- R5: Software can return to full speed at any time by writing 2'b01. `rate_q` shows the new value on the clock after the write.
- R6: When `swb_en` is 1, any `ext_irq` bit whose matching `ext_irq_en` bit is 1 sets the divide field to 2'b01 on the next clock. A masked request, or any request while `swb_en` is 0, leaves the field unchanged.
- R7: When `swb_en` is 1, any set bit of `ser_flags` sets the divide field to 2'b01 on the next clock. When `swb_en` is 0, these flags have no effect.
- R8: A write of 2'b10 or 2'b11 in a cycle where a switchback condition is present is ignored, and the field becomes 2'b01.
- R9: With no write and no switchback condition, the divide field keeps its value. This holds after a switchback as well.
- R10: A new divide field value is applied only when the current machine cycle completes. A cycle that is already running keeps its full length.
- R11: With the ring source selected (`src_ring` written as 1), only clocks where `ring_tick` is 1 count as ticks. With the crystal source selected, `ring_tick` is ignored. The source choice does not change the divide field.
- R12: `mc_en` is high for exactly one clock per machine cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal clock |
| rst | input | 1 | Synchronous active-high reset |
| ring_tick | input | 1 | Ring-oscillator tick enable |
| src_wr | input | 1 | Write strobe for source select |
| src_ring | input | 1 | Source to write: 1 = ring, 0 = crystal |
| rate_wr | input | 1 | Write strobe for the divide field |
| rate_wdata | input | 2 | Divide field value: 01 = /4, 10 = /64, 11 = /1024, 00 = /4 |
| swb_en | input | 1 | Hardware switchback enable |
| ext_irq | input | NIRQ | External interrupt requests |
| ext_irq_en | input | NIRQ | Per-request enables |
| ser_flags | input | NSER | Serial transmit/receive activity flags |
| mc_en | output | 1 | Machine-cycle enable pulse |
| rate_q | output | 2 | Stored divide field |
| src_ring_q | output | 1 | Selected source: 1 = ring |

## Verification
Divide-field results (writes, switchback, ignored writes) are due one clock after the stimulus edge. The bench therefore drives each table row on a falling edge and samples `rate_q` on the next falling edge. Rates are checked by counting falling edges between consecutive `mc_en` pulses. After any rate or source change, the first gap is thrown away, because the change only takes effect at the next boundary. The boundary test is the one exception: it puts the write one clock after a slow-rate pulse and expects the running gap to stay at 1024 before the next gap drops to 4.

// File: rtl/pm_cycle_pkg.sv
package pm_cycle_pkg;
  typedef enum logic [1:0] {
    RATE_RSVD = 2'b00,
    RATE_FULL = 2'b01,
    RATE_MID  = 2'b10,
    RATE_SLOW = 2'b11
  } rate_e;
endpackage

// File: rtl/pm_swb_detect.sv
module pm_swb_detect #(
  parameter int NIRQ = 6,
  parameter int NSER = 4
) (
  input  logic            swb_en,
  input  logic [NIRQ-1:0] ext_irq,
  input  logic [NIRQ-1:0] ext_irq_en,
  input  logic [NSER-1:0] ser_flags,
  output logic            swb_hit
);
  logic irq_any;
  logic ser_any;

  always_comb begin
    irq_any = |(ext_irq & ext_irq_en);
    ser_any = |ser_flags;
    swb_hit = swb_en & (irq_any | ser_any);
  end
endmodule

// File: rtl/pm_ctrl_regs.sv
module pm_ctrl_regs
  import pm_cycle_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       src_wr,
  input  logic       src_ring,
  input  logic       rate_wr,
  input  logic [1:0] rate_wdata,
  input  logic       swb_hit,
  output rate_e      req_rate,
  output logic       src_sel
);
  rate_e wr_rate;

  always_comb begin
    wr_rate = rate_e'(rate_wdata);
    if (wr_rate == RATE_RSVD) wr_rate = RATE_FULL;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_rate <= RATE_FULL;
      src_sel  <= 1'b0;
    end else begin
      if (swb_hit)      req_rate <= RATE_FULL;
      else if (rate_wr) req_rate <= wr_rate;
      if (src_wr) src_sel <= src_ring;
    end
  end

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (req_rate == RATE_FULL && !src_sel));
  p_legal_field_r2: assert property (@(posedge clk) disable iff (rst)
    req_rate != RATE_RSVD);
  p_swb_full_r6: assert property (@(posedge clk) disable iff (rst)
    swb_hit |=> req_rate == RATE_FULL);
  p_hold_field_r9: assert property (@(posedge clk) disable iff (rst)
    (!swb_hit && !rate_wr) |=> $stable(req_rate));
endmodule

// File: rtl/pm_cycle_gen.sv
module pm_cycle_gen
  import pm_cycle_pkg::*;
#(
  parameter int DIV_FULL = 4,
  parameter int DIV_MID  = 64,
  parameter int DIV_SLOW = 1024
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  src_sel,
  input  logic  ring_tick,
  input  rate_e req_rate,
  output logic  mc_en
);
  localparam int CNT_W = $clog2(DIV_SLOW);

  rate_e            cur_rate;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;
  logic             tick;

  always_comb begin
    tick = src_sel ? ring_tick : 1'b1;
    case (cur_rate)
      RATE_MID:  last = CNT_W'(DIV_MID - 1);
      RATE_SLOW: last = CNT_W'(DIV_SLOW - 1);
      default:   last = CNT_W'(DIV_FULL - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      mc_en    <= 1'b0;
      cur_rate <= RATE_FULL;
    end else begin
      mc_en <= 1'b0;
      if (tick) begin
        if (cnt == last) begin
          cnt      <= '0;
          mc_en    <= 1'b1;
          cur_rate <= req_rate;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  p_boundary_only_r10: assert property (@(posedge clk) disable iff (rst)
    !$stable(cur_rate) |-> mc_en);
  p_no_tick_r11: assert property (@(posedge clk) disable iff (rst)
    (src_sel && !ring_tick) |=> !mc_en);
  p_single_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    mc_en |=> !mc_en);
endmodule

// File: rtl/pm_cycle_rate.sv
module pm_cycle_rate
  import pm_cycle_pkg::*;
#(
  parameter int NIRQ     = 6,
  parameter int NSER     = 4,
  parameter int DIV_FULL = 4,
  parameter int DIV_MID  = 64,
  parameter int DIV_SLOW = 1024
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ring_tick,
  input  logic            src_wr,
  input  logic            src_ring,
  input  logic            rate_wr,
  input  logic [1:0]      rate_wdata,
  input  logic            swb_en,
  input  logic [NIRQ-1:0] ext_irq,
  input  logic [NIRQ-1:0] ext_irq_en,
  input  logic [NSER-1:0] ser_flags,
  output logic            mc_en,
  output logic [1:0]      rate_q,
  output logic            src_ring_q
);
  logic  swb_hit;
  rate_e req_rate;
  logic  src_sel;

  pm_swb_detect #(.NIRQ(NIRQ), .NSER(NSER)) u_detect (
    .swb_en(swb_en), .ext_irq(ext_irq), .ext_irq_en(ext_irq_en),
    .ser_flags(ser_flags), .swb_hit(swb_hit)
  );

  pm_ctrl_regs u_regs (
    .clk(clk), .rst(rst), .src_wr(src_wr), .src_ring(src_ring),
    .rate_wr(rate_wr), .rate_wdata(rate_wdata), .swb_hit(swb_hit),
    .req_rate(req_rate), .src_sel(src_sel)
  );

  pm_cycle_gen #(.DIV_FULL(DIV_FULL), .DIV_MID(DIV_MID), .DIV_SLOW(DIV_SLOW)) u_gen (
    .clk(clk), .rst(rst), .src_sel(src_sel), .ring_tick(ring_tick),
    .req_rate(req_rate), .mc_en(mc_en)
  );

  assign rate_q     = req_rate;
  assign src_ring_q = src_sel;
endmodule

// File: tb/tb_pm_cycle_rate.sv
module tb_pm_cycle_rate;
  localparam int CLK_PERIOD = 10;
  localparam int NIRQ = 6;
  localparam int NSER = 4;
  // row: [8]wr [7:6]wdata [5]swb_en [4]irq2 [3]irq2_en [2]ser1 [1:0]expected rate_q
  localparam int NROW = 14;
  localparam logic [8:0] VEC [NROW] = '{
    9'b1_10_0_0_0_0_10, // R5 style write to /64
    9'b1_11_0_0_0_0_11, // write /1024
    9'b0_00_1_1_0_0_11, // R6 masked request
    9'b0_00_0_1_1_0_11, // R6 switchback off
    9'b0_00_0_0_0_1_11, // R7 switchback off
    9'b0_00_1_1_1_0_01, // R6 forces full
    9'b0_00_1_0_0_0_01, // R9 stays
    9'b1_10_1_0_0_1_01, // R8 ignored write
    9'b1_10_1_0_0_0_10, // write accepted
    9'b0_00_1_0_0_1_01, // R7 forces full
    9'b1_11_0_0_0_0_11,
    9'b1_00_0_0_0_0_01, // R2 00 stored as 01
    9'b1_11_0_0_0_0_11,
    9'b1_01_0_0_0_0_01  // R5 return to full
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ring_tick = 1'b0;
  logic src_wr = 1'b0, src_ring = 1'b0;
  logic rate_wr = 1'b0;
  logic [1:0] rate_wdata = 2'b00;
  logic swb_en = 1'b0;
  logic [NIRQ-1:0] ext_irq = '0, ext_irq_en = '0;
  logic [NSER-1:0] ser_flags = '0;
  logic mc_en;
  logic [1:0] rate_q;
  logic src_ring_q;

  int checks = 0;
  int errors = 0;

  pm_cycle_rate #(.NIRQ(NIRQ), .NSER(NSER)) dut (
    .clk(clk), .rst(rst), .ring_tick(ring_tick), .src_wr(src_wr),
    .src_ring(src_ring), .rate_wr(rate_wr), .rate_wdata(rate_wdata),
    .swb_en(swb_en), .ext_irq(ext_irq), .ext_irq_en(ext_irq_en),
    .ser_flags(ser_flags), .mc_en(mc_en), .rate_q(rate_q), .src_ring_q(src_ring_q)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // ring tick every third clock, always running
  initial begin
    int k = 0;
    forever begin
      @(negedge clk);
      ring_tick = (k % 3 == 0);
      k++;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic gap(output int g);
    @(negedge clk);
    while (!mc_en) @(negedge clk);
    g = 0;
    do begin @(negedge clk); g++; end while (!mc_en);
  endtask

  task automatic write_rate(input logic [1:0] d);
    @(negedge clk);
    rate_wr = 1'b1; rate_wdata = d;
    @(negedge clk);
    rate_wr = 1'b0;
  endtask

  task automatic write_src(input logic s);
    @(negedge clk);
    src_wr = 1'b1; src_ring = s;
    @(negedge clk);
    src_wr = 1'b0;
  endtask

  initial begin
    int g;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(rate_q == 2'b01, "R1 rate", rate_q, 1);
    chk(src_ring_q == 1'b0, "R1 src", src_ring_q, 0);
    chk(mc_en == 1'b0, "R1 mc_en", mc_en, 0);
    rst = 1'b0;

    // R2 full rate; R11 ring ticks ignored on crystal
    gap(g); gap(g);
    chk(g == 4, "R2 gap", g, 4);
    @(negedge clk);
    while (!mc_en) @(negedge clk);
    @(negedge clk);
    chk(mc_en == 1'b0, "R12 width", mc_en, 0);

    // table walk: R5 R6 R7 R8 R9 R2
    for (int i = 0; i < NROW; i++) begin
      @(negedge clk);
      rate_wr = VEC[i][8]; rate_wdata = VEC[i][7:6]; swb_en = VEC[i][5];
      ext_irq = '0; ext_irq_en = '0; ser_flags = '0;
      ext_irq[2] = VEC[i][4]; ext_irq_en[2] = VEC[i][3]; ser_flags[1] = VEC[i][2];
      @(negedge clk);
      rate_wr = 1'b0; swb_en = 1'b0; ext_irq = '0; ext_irq_en = '0; ser_flags = '0;
      chk(rate_q == VEC[i][1:0], $sformatf("R5 R6 R7 R8 R9 row %0d", i), rate_q, VEC[i][1:0]);
    end

    // R3 /64
    write_rate(2'b10);
    gap(g); gap(g);
    chk(g == 64, "R3 gap", g, 64);
    // R4 /1024
    write_rate(2'b11);
    gap(g); gap(g);
    chk(g == 1024, "R4 gap", g, 1024);

    // R10 boundary: full-speed write just after a slow pulse
    @(negedge clk);
    while (!mc_en) @(negedge clk);
    rate_wr = 1'b1; rate_wdata = 2'b01;
    g = 0;
    do begin
      @(negedge clk); g++;
      if (g == 1) rate_wr = 1'b0;
      if (g == 1) chk(rate_q == 2'b01, "R5 readback", rate_q, 1);
    end while (!mc_en);
    chk(g == 1024, "R10 running gap", g, 1024);
    gap(g);
    chk(g == 4, "R10 next gap", g, 4);

    // R2 write 00 behaves as /4
    write_rate(2'b10);
    gap(g);
    write_rate(2'b00);
    chk(rate_q == 2'b01, "R2 00 readback", rate_q, 1);
    gap(g); gap(g);
    chk(g == 4, "R2 00 gap", g, 4);

    // R11 ring source
    write_src(1'b1);
    chk(src_ring_q == 1'b1, "R11 src", src_ring_q, 1);
    chk(rate_q == 2'b01, "R11 rate kept", rate_q, 1);
    gap(g); gap(g);
    chk(g == 12, "R11 ring gap", g, 12);
    write_src(1'b0);
    gap(g); gap(g);
    chk(g == 4, "R11 crystal gap", g, 4);

    // R1 reset mid-run
    write_rate(2'b11);
    write_src(1'b1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    chk(rate_q == 2'b01, "R1 rerst rate", rate_q, 1);
    chk(src_ring_q == 1'b0, "R1 rerst src", src_ring_q, 0);
    chk(mc_en == 1'b0, "R1 rerst mc_en", mc_en, 0);
    rst = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule